// File: doc/BRIEF.md
# Byte-Lane Write Enabler for a Pipelined Subordinate Bus Port

This block sits on the subordinate side of an AHB5 bus in front of a small local word array. It accepts write transfers and turns each one into a set of per-byte write enables. The address phase fixes which byte lanes a transfer may touch: the decoded offset's low bits and the transfer size select them. The data phase then supplies the write data and the per-lane write strobes. A lane is written only when it is active for the address and size and its strobe is also high. A strobe on a lane that the address and size leave inactive has no effect.

A write that leaves any of its active lanes unstrobed is a sparse write. The block reports it with a pulse during that write's data phase. A manager that has no strobe support drives every strobe high, and its transfers come out as ordinary writes of the full transfer size. The port never stalls and never signals an error. A combinational tap returns any stored word, so the array contents can be observed.

Top module: `ahb_lane_writer`

## Requirements
- R1: Active lanes come only from the registered offset bits [1:0] and size. Size 0 activates the one lane named by offset[1:0]. Size 1 activates lanes {1,0} when offset[1]=0 and lanes {3,2} when offset[1]=1. Size 2, and any larger size, activates all four lanes.
- R2: During a write's data phase, `wr_be[i]` equals the active-lane bit i ANDed with `hwstrb[i]`. Bit i covers data bits [8i+7:8i]. After that cycle the addressed word holds the new byte on exactly those lanes.
- R3: A write with `hwstrb`=4'hF stores all the active lanes of its size and raises no sparse flag.
- R4: `sparse` is high in a write's data phase exactly when some active lane has its strobe low. It lasts one cycle and is low in the cycle that follows.
- R5: A strobe bit on an inactive lane never sets `wr_be` and never changes a stored byte.
- R6: A transfer that is unselected, or that is IDLE (htrans 2'b00), BUSY (2'b01) or a read (hwrite=0), produces no `wr_en`, no byte enables, no sparse flag and no change to storage in the next cycle.
- R7: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R8: Address-phase controls are captured when `hready` is high, `hsel` is high, `hwrite` is high and htrans is NONSEQ (2'b10) or SEQ (2'b11). Strobes and data are taken in the following cycle. Back-to-back writes overlap, with one write's data phase falling in the next write's address phase.
- R9: The array holds 16 words of 32 bits, indexed by offset[5:2], and is all zero after reset. `tap_word` shows the word at `tap_idx` in the same cycle.
- R10: While `hready` is low, a pending data phase is held. No write happens and no new address phase is captured until `hready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | 6 | Decoded byte offset within the window |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write (1) or read (0) |
| hsize | input | 3 | Transfer size, log2 of bytes |
| hready | input | 1 | Bus-wide transfer-done indication |
| hwdata | input | 32 | Write data (data phase) |
| hwstrb | input | 4 | Per-lane write strobes (data phase) |
| hreadyout | output | 1 | Always-ready response |
| hresp | output | 1 | Response, always OKAY |
| wr_en | output | 1 | A write data phase completes this cycle |
| wr_be | output | 4 | Final per-byte enables |
| sparse | output | 1 | Sparse-write pulse |
| tap_idx | input | 4 | Word index to observe |
| tap_word | output | 32 | Stored word at tap_idx |

## Verification
The assertions check several properties on every cycle. The response is constant. A write enable is always preceded by a qualifying address phase, and the sparse flag never appears without one. A full strobe never raises the flag. A byte-size write never enables more than one lane. Captured controls hold while `hready` is low. Each write changes only its enabled bytes and leaves the others alone. Other properties need the bench's sweep over every size, offset and strobe pattern, which compares enables, flags and stored words with arithmetic expectations. These are the exact lane choice for each offset, the masking of inactive-lane strobes, and the overlap of back-to-back writes.

// File: rtl/ahb_lane_pkg.sv
package ahb_lane_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    localparam logic RESP_OKAY = 1'b0;

    function automatic logic is_transfer(input logic [1:0] tr);
        return (tr == TR_NONSEQ) || (tr == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahb_lane_capture.sv
module ahb_lane_capture #(
    parameter int ADDR_W = 6,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [SIZE_W-1:0] hsize,
    output logic              dp_valid,
    output logic [ADDR_W-1:0] dp_addr,
    output logic [SIZE_W-1:0] dp_size
);
    import ahb_lane_pkg::*;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (hready) begin
            ctl_d.vld  = hsel && hwrite && is_transfer(htrans);
            ctl_d.addr = haddr;
            ctl_d.size = hsize;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign dp_valid = ctl_q.vld;
    assign dp_addr  = ctl_q.addr;
    assign dp_size  = ctl_q.size;

    // R10: a stalled data phase keeps its controls
    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(ctl_q));

endmodule

// File: rtl/ahb_lane_decode.sv
module ahb_lane_decode #(
    parameter int LANES  = 4,
    parameter int SIZE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dp_valid,
    input  logic                       hready,
    input  logic [$clog2(LANES)-1:0]   lane_off,
    input  logic [SIZE_W-1:0]          dp_size,
    input  logic [LANES-1:0]           hwstrb,
    output logic                       wr_en,
    output logic [LANES-1:0]           lane_act,
    output logic [LANES-1:0]           be,
    output logic                       sparse
);
    localparam int LB = $clog2(LANES);

    logic [SIZE_W-1:0] sz_eff;

    always_comb begin
        sz_eff = (dp_size > SIZE_W'(LB)) ? SIZE_W'(LB) : dp_size;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [LB-1:0] LIDX = LB'(i);
        always_comb begin
            lane_act[i] = (((LIDX ^ lane_off) >> sz_eff) == '0);
        end
    end

    always_comb begin
        wr_en  = dp_valid && hready;
        be     = wr_en ? (lane_act & hwstrb) : '0;
        sparse = wr_en && ((lane_act & ~hwstrb) != '0);
    end

    // R1: a byte-size write enables at most one lane
    a_r1_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dp_size == '0) |-> ($countones(be) <= 1));

endmodule

// File: rtl/ahb_lane_store.sv
module ahb_lane_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W/8-1:0]      be,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] tap_idx,
    output logic [DATA_W-1:0]        tap_word
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } st_t;

    st_t st_d, st_q;
    logic [DATA_W-1:0] bit_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign bit_mask[l*8 +: 8] = {8{be[l]}};
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[idx] = (st_q.mem[idx] & ~bit_mask) | (wdata & bit_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_word = st_q.mem[tap_idx];

    // R5: bytes without an enable keep their value
    a_r5_other_lanes_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((st_q.mem[$past(idx)] ^ $past(st_q.mem[idx])) & ~$past(bit_mask)) == '0));

    // R2: enabled bytes take the write data
    a_r2_enabled_written: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((st_q.mem[$past(idx)] & $past(bit_mask)) == ($past(wdata) & $past(bit_mask))));

endmodule

// File: rtl/ahb_lane_writer.sv
module ahb_lane_writer #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int SIZE_W = 3,
    localparam int LANES  = DATA_W / 8,
    localparam int LB     = $clog2(LANES),
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + LB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [SIZE_W-1:0] hsize,
    input  logic              hready,
    input  logic [DATA_W-1:0] hwdata,
    input  logic [LANES-1:0]  hwstrb,
    output logic              hreadyout,
    output logic              hresp,
    output logic              wr_en,
    output logic [LANES-1:0]  wr_be,
    output logic              sparse,
    input  logic [IDX_W-1:0]  tap_idx,
    output logic [DATA_W-1:0] tap_word
);
    import ahb_lane_pkg::*;

    logic              dp_valid;
    logic [ADDR_W-1:0] dp_addr;
    logic [SIZE_W-1:0] dp_size;
    logic [LANES-1:0]  lane_act;

    assign hreadyout = 1'b1;
    assign hresp     = RESP_OKAY;

    ahb_lane_capture #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready(hready),
        .htrans(htrans), .hwrite(hwrite), .haddr(haddr), .hsize(hsize),
        .dp_valid(dp_valid), .dp_addr(dp_addr), .dp_size(dp_size)
    );

    ahb_lane_decode #(.LANES(LANES), .SIZE_W(SIZE_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .dp_valid(dp_valid), .hready(hready),
        .lane_off(dp_addr[LB-1:0]), .dp_size(dp_size), .hwstrb(hwstrb),
        .wr_en(wr_en), .lane_act(lane_act), .be(wr_be), .sparse(sparse)
    );

    ahb_lane_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .be(wr_be),
        .idx(dp_addr[ADDR_W-1:LB]), .wdata(hwdata),
        .tap_idx(tap_idx), .tap_word(tap_word)
    );

    // R7: never stalls, never errors
    a_r7_ready_okay: assert property (@(posedge clk) disable iff (!rst_n)
        hreadyout && (hresp == RESP_OKAY));

    // R6/R8: a write enable follows a qualifying address phase
    a_r6_write_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(hready)) |-> $past(hsel && hwrite && is_transfer(htrans)));

    // R4: sparse flag only inside a write data phase
    a_r4_sparse_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        sparse |-> wr_en);

    // R3: all strobes high is never sparse
    a_r3_full_strobe_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hwstrb == '1) |-> !sparse);

    // R5: an enabled lane is always an active lane
    a_r5_be_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_be & ~lane_act) == '0);

endmodule

// File: tb/ahb_lane_writer_bench.sv
module ahb_lane_writer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [5:0]  haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = '0;
    logic        hready = 1'b1;
    logic [31:0] hwdata = '0;
    logic [3:0]  hwstrb = '0;
    logic        hreadyout, hresp, wr_en, sparse;
    logic [3:0]  wr_be;
    logic [3:0]  tap_idx = '0;
    logic [31:0] tap_word;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [31:0] exp_mem [16];

    always #10 clk = ~clk;

    ahb_lane_writer u_ahb_lane_writer (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hready(hready), .hwdata(hwdata),
        .hwstrb(hwstrb), .hreadyout(hreadyout), .hresp(hresp), .wr_en(wr_en),
        .wr_be(wr_be), .sparse(sparse), .tap_idx(tap_idx), .tap_word(tap_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] act_mask(input logic [1:0] off, input int sz);
        if (sz == 0) return 4'b0001 << off;
        if (sz == 1) return 4'b0011 << {off[1], 1'b0};
        return 4'b1111;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] r = old;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = d[l*8 +: 8];
        return r;
    endfunction

    task automatic addr_phase(input logic sel, input logic [1:0] tr, input logic wr,
                              input logic [5:0] a, input logic [2:0] sz);
        hsel = sel; htrans = tr; hwrite = wr; haddr = a; hsize = sz;
    endtask

    task automatic go_idle();
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0;
    endtask

    task automatic single_write(input logic [3:0] idx, input logic [1:0] off, input int sz,
                                input logic [3:0] strb, input logic [31:0] d);
        logic [3:0] m;
        logic [3:0] ebe;
        string tag;
        m = act_mask(off, sz);
        ebe = m & strb;
        tag = (strb == 4'hF) ? "R3" : (((strb & ~m) != 0) ? "R5" : "R2");
        @(negedge clk);
        addr_phase(1'b1, 2'b10, 1'b1, {idx, off}, 3'(sz));
        hwstrb = 4'h0; hwdata = '0;
        @(negedge clk);
        go_idle();
        hwdata = d; hwstrb = strb; tap_idx = idx;
        #2;
        check(wr_en === 1'b1, "R8", 32'(wr_en), 32'd1);
        check(wr_be === ebe, tag, 32'(wr_be), 32'(ebe));
        check(sparse === ((m & ~strb) != 0), "R4", 32'(sparse), 32'((m & ~strb) != 0));
        exp_mem[idx] = merge(exp_mem[idx], d, ebe);
        @(negedge clk);
        #2;
        check(tap_word === exp_mem[idx], "R1", tap_word, exp_mem[idx]);
        check(sparse === 1'b0, "R4", 32'(sparse), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n = 0;
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state, R7 response
        for (int i = 0; i < 16; i++) begin
            tap_idx = 4'(i); #1;
            check(tap_word === 32'h0, "R9", tap_word, 32'h0);
        end
        check(hreadyout === 1'b1 && hresp === 1'b0, "R7", {hreadyout, hresp}, 32'h2);
        check(wr_en === 1'b0, "R6", 32'(wr_en), 32'd0);

        // R1/R2/R3/R4/R5 exhaustive sweep
        for (int sz = 0; sz < 3; sz++)
            for (int off = 0; off < 4; off++)
                for (int s = 0; s < 16; s++) begin
                    single_write(4'(n % 16), 2'(off), sz, 4'(s), 32'h9E37_79B9 * (n + 1));
                    n++;
                end
        // R1: size above word clamps to all lanes
        single_write(4'd5, 2'd1, 3, 4'hF, 32'hCAFE_F00D);

        // R6: non-writes do nothing
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            case (k)
                0: addr_phase(1'b1, 2'b00, 1'b1, 6'h0C, 3'd2);
                1: addr_phase(1'b1, 2'b01, 1'b1, 6'h0C, 3'd2);
                2: addr_phase(1'b1, 2'b10, 1'b0, 6'h0C, 3'd2);
                default: addr_phase(1'b0, 2'b10, 1'b1, 6'h0C, 3'd2);
            endcase
            @(negedge clk);
            go_idle(); hwdata = 32'hDEAD_BEEF; hwstrb = 4'hF; tap_idx = 4'd3;
            #2;
            check(wr_en === 1'b0 && wr_be === 4'h0, "R6", {wr_en, wr_be}, 32'h0);
            check(sparse === 1'b0, "R6", 32'(sparse), 32'd0);
            @(negedge clk); #2;
            check(tap_word === exp_mem[3], "R6", tap_word, exp_mem[3]);
        end

        // R8: back-to-back overlapped writes
        @(negedge clk);
        addr_phase(1'b1, 2'b10, 1'b1, {4'd7, 2'd2}, 3'd1);
        @(negedge clk);
        addr_phase(1'b1, 2'b11, 1'b1, {4'd8, 2'd0}, 3'd0);
        hwdata = 32'h1122_3344; hwstrb = 4'hF;
        #2;
        check(wr_be === 4'b1100, "R8", 32'(wr_be), 32'hC);
        exp_mem[7] = merge(exp_mem[7], 32'h1122_3344, 4'b1100);
        @(negedge clk);
        go_idle(); hwdata = 32'h5566_7788; hwstrb = 4'b1110;
        #2;
        check(wr_be === 4'b0000 && sparse === 1'b1, "R8", {sparse, wr_be}, 32'h10);
        @(negedge clk);
        tap_idx = 4'd7; #2;
        check(tap_word === exp_mem[7], "R8", tap_word, exp_mem[7]);
        tap_idx = 4'd8; #1;
        check(tap_word === exp_mem[8], "R8", tap_word, exp_mem[8]);

        // R10: stalled data phase
        @(negedge clk);
        addr_phase(1'b1, 2'b10, 1'b1, {4'd9, 2'd0}, 3'd2);
        @(negedge clk);
        go_idle(); hready = 1'b0; hwdata = 32'hBAD0_BAD0; hwstrb = 4'hF; tap_idx = 4'd9;
        #2;
        check(wr_en === 1'b0, "R10", 32'(wr_en), 32'd0);
        @(negedge clk);
        hready = 1'b1; hwdata = 32'hA5A5_0F0F; hwstrb = 4'b0101;
        #2;
        check(wr_en === 1'b1 && wr_be === 4'b0101, "R10", {wr_en, wr_be}, 32'h15);
        exp_mem[9] = merge(exp_mem[9], 32'hA5A5_0F0F, 4'b0101);
        @(negedge clk); #2;
        check(tap_word === exp_mem[9], "R10", tap_word, exp_mem[9]);
        check(hreadyout === 1'b1 && hresp === 1'b0, "R7", {hreadyout, hresp}, 32'h2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule